// File: doc/BRIEF.md
# Multi-Channel DMA Register File and Interrupt Combiner

This block is the software-visible control plane of a sixteen-channel DMA engine. A processor reaches it over a simple single-cycle register port with a byte offset, a write strobe, write data and combinational read data. Each channel has four parameter registers: base address, line length, line count and control. There is also a line stride register for each channel. These values drive the channel address engines directly, which sit outside this block.

Several registers are shared by all channels: a write-one-to-clear interrupt status word, an interrupt enable word, a loop-run word and a stop register. The enable word and the loop word each have a second offset, and writing ones to that offset removes the matching bits without a read-modify-write. A channel runs in loop mode only while both of its two loop bits are set. A write to a channel's base register sends a one-cycle start strobe to that channel. Event pulses from the engines are collected as status bits, and these are combined with the enable word into a single interrupt line.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset every register reads zero, irq is low and all start, stop and loop outputs are zero.
- R2: Channel c owns offsets c*0x10 to c*0x10+0xC. A write to +0x4 stores the line length (low 16 bits) and a write to +0x8 stores the line count (low 16 bits). Each value reads back zero-extended and appears on that channel's slice of ch_xlen or ch_ylen from the next cycle.
- R3: A write to offset c*0x10+0x0 stores the full 32-bit word on ch_base_addr for channel c. In the next cycle it raises ch_start[c], and only that bit, for exactly one cycle. A read of that offset returns ch_cur_addr for channel c.
- R4: Offset 0x100+4*c holds the 16-bit line stride of channel c. It is read/write and is driven on ch_stride.
- R5: Offset 0x144 is interrupt status, one bit per channel. A ch_event[c] pulse sets bit c, and writing 1 to bit c clears it. When a set and a clear of the same bit happen in the same cycle, the bit ends up set.
- R6: Offset 0x148 is the read/write interrupt enable word. Writing ones to offset 0x14C clears those enable bits, and offset 0x14C reads zero.
- R7: irq is the OR over all channels of status AND enable. It follows register changes in the cycle after the causing edge.
- R8: Offset 0x150 is the 32-bit loop word, read/write. ch_loop[c] is high only when bits c and c+16 are both set. Writing ones to offset 0x15C clears those bits, and offset 0x15C reads zero.
- R9: Writing 1 to bit c of offset 0x140 gives ch_stop[c] a one-cycle pulse in the next cycle. Offset 0x140 reads zero.
- R10: Misaligned offsets and offsets that no register occupies read zero, and writes to them change nothing.
- R11: A write to offset c*0x10+0xC stores the control bits [5:0]. Bits [3:0] are a channel tag driven on ch_tag, bit 4 is the burst mode driven on ch_mode[c], and bit 5 is the direction driven on ch_dir[c]. Upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ch_event | input | 16 | Per-channel completion event pulses |
| ch_cur_addr | input | 512 | Live address of each channel, 32 bits per channel |
| ch_base_addr | output | 512 | Programmed base address, 32 bits per channel |
| ch_xlen | output | 256 | Line length, 16 bits per channel |
| ch_ylen | output | 256 | Line count, 16 bits per channel |
| ch_stride | output | 256 | Line stride, 16 bits per channel |
| ch_tag | output | 64 | Control tag, 4 bits per channel |
| ch_mode | output | 16 | Burst mode bit per channel |
| ch_dir | output | 16 | Direction bit per channel |
| ch_start | output | 16 | One-cycle start strobe per channel |
| ch_stop | output | 16 | One-cycle stop strobe per channel |
| ch_loop | output | 16 | Loop-run level per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is an event pulse that lands on the same edge as a write-one-to-clear of that same status bit, because the set must win. A directed step produces this coincidence on purpose. The random phase also overlaps sparse event pulses with status-clear writes that carry random masks, so partial overlaps occur many times. A half-set loop pair, where only one of a channel's two loop bits is set, is likewise produced both directly and through random loop-word data.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
   localparam logic [8:0] OFS_STRIDE = 9'h100;
   localparam logic [8:0] OFS_STOP   = 9'h140;
   localparam logic [8:0] OFS_ISTAT  = 9'h144;
   localparam logic [8:0] OFS_IEN    = 9'h148;
   localparam logic [8:0] OFS_IENCLR = 9'h14C;
   localparam logic [8:0] OFS_LOOP   = 9'h150;
   localparam logic [8:0] OFS_LPCLR  = 9'h15C;
   localparam int         TAG_W      = 4;
   localparam int         CTRL_W     = 6;

   typedef enum logic [1:0] {
      FLD_BASE = 2'd0,
      FLD_XLEN = 2'd1,
      FLD_YLEN = 2'd2,
      FLD_CTRL = 2'd3
   } chfld_e;

   typedef struct packed {
      logic       ch_hit;
      logic [3:0] ch_idx;
      chfld_e     fld;
      logic       wid_hit;
      logic [3:0] wid_idx;
      logic       stop_hit;
      logic       ist_hit;
      logic       ien_hit;
      logic       ienclr_hit;
      logic       loop_hit;
      logic       lpclr_hit;
   } dec_t;

   function automatic logic [31:0] loop_mask(input int n);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < n; i++) begin
         m[i]      = 1'b1;
         m[i + 16] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/dma_regs_dec.sv
module dma_regs_dec
   import dma_regs_pkg::*;
#(
   parameter int NCH = 16,
   parameter int AW  = 9
) (
   input  logic [AW-1:0] addr,
   output dec_t          dec
);
   localparam int CH_END  = NCH * 16;
   localparam int WID_END = 256 + NCH * 4;

   int   a;
   logic aligned;

   always_comb begin
      a       = int'(addr);
      aligned = (addr[1:0] == 2'b00);
      dec            = '0;
      dec.ch_idx     = addr[7:4];
      dec.fld        = chfld_e'(addr[3:2]);
      dec.wid_idx    = addr[5:2];
      dec.ch_hit     = aligned && (a < CH_END);
      dec.wid_hit    = aligned && (a >= 256) && (a < WID_END);
      dec.stop_hit   = (a == int'(OFS_STOP));
      dec.ist_hit    = (a == int'(OFS_ISTAT));
      dec.ien_hit    = (a == int'(OFS_IEN));
      dec.ienclr_hit = (a == int'(OFS_IENCLR));
      dec.loop_hit   = (a == int'(OFS_LOOP));
      dec.lpclr_hit  = (a == int'(OFS_LPCLR));
   end
endmodule

// File: rtl/dma_bitreg.sv
module dma_bitreg #(
   parameter int           W      = 16,
   parameter bit           STICKY = 1'b0,
   parameter logic [W-1:0] MASK   = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic         clr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] set,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   generate
      if (STICKY) begin : g_w1c
         always_comb begin
            nxt = q & ~((wr || clr) ? wdata : '0);
            nxt = nxt | set;
         end
      end else begin : g_rw
         always_comb begin
            if (wr)       nxt = wdata;
            else if (clr) nxt = q & ~wdata;
            else          nxt = q;
            nxt = nxt | set;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt & MASK;
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_regs_pkg::*;
#(
   parameter int DW     = 32,
   parameter int BASE_W = 32,
   parameter int LEN_W  = 16,
   parameter int WID_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_wr,
   input  chfld_e            fld,
   input  logic              wid_wr,
   input  logic [DW-1:0]     wdata,
   output logic [BASE_W-1:0] base,
   output logic [LEN_W-1:0]  xlen,
   output logic [LEN_W-1:0]  ylen,
   output logic [WID_W-1:0]  stride,
   output logic [CTRL_W-1:0] ctrl,
   output logic              start
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base   <= '0;
         xlen   <= '0;
         ylen   <= '0;
         ctrl   <= '0;
         stride <= '0;
         start  <= 1'b0;
      end else begin
         start <= win_wr && (fld == FLD_BASE);
         if (win_wr) begin
            case (fld)
               FLD_BASE: base <= wdata[BASE_W-1:0];
               FLD_XLEN: xlen <= wdata[LEN_W-1:0];
               FLD_YLEN: ylen <= wdata[LEN_W-1:0];
               FLD_CTRL: ctrl <= wdata[CTRL_W-1:0];
               default:  ;
            endcase
         end
         if (wid_wr) stride <= wdata[WID_W-1:0];
      end
   end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
   import dma_regs_pkg::*;
#(
   parameter int NCH    = 16,
   parameter int AW     = 9,
   parameter int DW     = 32,
   parameter int BASE_W = 32,
   parameter int LEN_W  = 16,
   parameter int WID_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr,
   input  logic [AW-1:0]           reg_addr,
   input  logic [DW-1:0]           reg_wdata,
   output logic [DW-1:0]           reg_rdata,
   input  logic [NCH-1:0]          ch_event,
   input  logic [NCH*BASE_W-1:0]   ch_cur_addr,
   output logic [NCH*BASE_W-1:0]   ch_base_addr,
   output logic [NCH*LEN_W-1:0]    ch_xlen,
   output logic [NCH*LEN_W-1:0]    ch_ylen,
   output logic [NCH*WID_W-1:0]    ch_stride,
   output logic [NCH*TAG_W-1:0]    ch_tag,
   output logic [NCH-1:0]          ch_mode,
   output logic [NCH-1:0]          ch_dir,
   output logic [NCH-1:0]          ch_start,
   output logic [NCH-1:0]          ch_stop,
   output logic [NCH-1:0]          ch_loop,
   output logic                    irq
);
   localparam logic [31:0] LMASK = loop_mask(NCH);

   generate
      if (NCH < 1 || NCH > 16) begin : g_bad_nch
         $error("dma_ctl_regs: NCH must lie in 1..16");
      end
      if (AW != 9) begin : g_bad_aw
         $error("dma_ctl_regs: AW must be 9");
      end
      if (DW != 32) begin : g_bad_dw
         $error("dma_ctl_regs: DW must be 32");
      end
      if (BASE_W > DW || LEN_W > DW || WID_W > DW) begin : g_bad_fld
         $error("dma_ctl_regs: field wider than data bus");
      end
   endgenerate

   dec_t dec;

   dma_regs_dec #(.NCH(NCH), .AW(AW)) u_dec (
      .addr (reg_addr),
      .dec  (dec)
   );

   logic [CTRL_W-1:0] ctrl_q [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic win_wr;
      logic wid_wr;
      assign win_wr = reg_wr && dec.ch_hit  && (int'(dec.ch_idx)  == c);
      assign wid_wr = reg_wr && dec.wid_hit && (int'(dec.wid_idx) == c);

      dma_chan_regs #(
         .DW(DW), .BASE_W(BASE_W), .LEN_W(LEN_W), .WID_W(WID_W)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .win_wr (win_wr),
         .fld    (dec.fld),
         .wid_wr (wid_wr),
         .wdata  (reg_wdata),
         .base   (ch_base_addr[c*BASE_W +: BASE_W]),
         .xlen   (ch_xlen[c*LEN_W +: LEN_W]),
         .ylen   (ch_ylen[c*LEN_W +: LEN_W]),
         .stride (ch_stride[c*WID_W +: WID_W]),
         .ctrl   (ctrl_q[c]),
         .start  (ch_start[c])
      );

      assign ch_tag[c*TAG_W +: TAG_W] = ctrl_q[c][TAG_W-1:0];
      assign ch_mode[c]               = ctrl_q[c][4];
      assign ch_dir[c]                = ctrl_q[c][5];
   end

   logic [NCH-1:0] ist_q, ien_q;
   logic [31:0]    loop_q;

   dma_bitreg #(.W(NCH), .STICKY(1'b1)) u_ist (
      .clk(clk), .rst_n(rst_n),
      .wr(reg_wr && dec.ist_hit), .clr(1'b0),
      .wdata(reg_wdata[NCH-1:0]), .set(ch_event), .q(ist_q)
   );

   dma_bitreg #(.W(NCH), .STICKY(1'b0)) u_ien (
      .clk(clk), .rst_n(rst_n),
      .wr(reg_wr && dec.ien_hit), .clr(reg_wr && dec.ienclr_hit),
      .wdata(reg_wdata[NCH-1:0]), .set('0), .q(ien_q)
   );

   dma_bitreg #(.W(32), .STICKY(1'b0), .MASK(LMASK)) u_loop (
      .clk(clk), .rst_n(rst_n),
      .wr(reg_wr && dec.loop_hit), .clr(reg_wr && dec.lpclr_hit),
      .wdata(reg_wdata), .set('0), .q(loop_q)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_loop
      assign ch_loop[c] = loop_q[c] & loop_q[c + 16];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ch_stop <= '0;
      else if (reg_wr && dec.stop_hit)   ch_stop <= reg_wdata[NCH-1:0];
      else                               ch_stop <= '0;
   end

   assign irq = |(ist_q & ien_q);

   logic [CTRL_W-1:0] rd_ctrl;
   assign rd_ctrl = ctrl_q[dec.ch_idx];

   always_comb begin
      reg_rdata = '0;
      if (dec.ch_hit) begin
         case (dec.fld)
            FLD_BASE: reg_rdata[BASE_W-1:0] = ch_cur_addr[dec.ch_idx*BASE_W +: BASE_W];
            FLD_XLEN: reg_rdata[LEN_W-1:0]  = ch_xlen[dec.ch_idx*LEN_W +: LEN_W];
            FLD_YLEN: reg_rdata[LEN_W-1:0]  = ch_ylen[dec.ch_idx*LEN_W +: LEN_W];
            FLD_CTRL: reg_rdata[CTRL_W-1:0] = rd_ctrl;
            default:  reg_rdata = '0;
         endcase
      end else if (dec.wid_hit) begin
         reg_rdata[WID_W-1:0] = ch_stride[dec.wid_idx*WID_W +: WID_W];
      end else if (dec.ist_hit) begin
         reg_rdata[NCH-1:0] = ist_q;
      end else if (dec.ien_hit) begin
         reg_rdata[NCH-1:0] = ien_q;
      end else if (dec.loop_hit) begin
         reg_rdata = loop_q;
      end
   end
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk #(
   parameter int NCH = 16,
   parameter int AW  = 9,
   parameter int DW  = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           reg_wr,
   input logic [AW-1:0]  reg_addr,
   input logic [DW-1:0]  reg_wdata,
   input logic [DW-1:0]  reg_rdata,
   input logic [NCH-1:0] ch_event,
   input logic [NCH-1:0] ch_start,
   input logic [NCH-1:0] ch_stop,
   input logic [NCH-1:0] ch_loop,
   input logic           irq
);
   AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ch_start)); // R3
   AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (ch_start != '0) |-> $past(reg_wr)); // R3
   AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (ch_stop != '0) |-> $past(reg_wr && reg_addr == AW'(9'h140))); // R9
   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $past(ch_event != '0 || reg_wr)); // R7
   AST_IEN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && reg_addr == AW'(9'h14C) && (&reg_wdata)) |=> !irq); // R6
   AST_LOOP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && reg_addr == AW'(9'h15C) && (&reg_wdata)) |=> (ch_loop == '0)); // R8
   AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (reg_addr > AW'(9'h15C)) |-> (reg_rdata == '0)); // R10
   AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (reg_addr[1:0] != 2'b00) |-> (reg_rdata == '0)); // R10
endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_event(ch_event),
   .ch_start(ch_start), .ch_stop(ch_stop), .ch_loop(ch_loop), .irq(irq)
);

// File: tb/sim_dma_ctl_regs.sv
`timescale 1ns/1ps
module sim_dma_ctl_regs;
   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [8:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [N-1:0]  ch_event = '0;
   logic [N*32-1:0] ch_cur_addr = '0;
   logic [N*32-1:0] ch_base_addr;
   logic [N*16-1:0] ch_xlen, ch_ylen, ch_stride;
   logic [N*4-1:0]  ch_tag;
   logic [N-1:0]  ch_mode, ch_dir, ch_start, ch_stop, ch_loop;
   logic          irq;

   always #4 clk = ~clk;

   dma_ctl_regs u0 (.*);

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [31:0] m_base [N];
   logic [15:0] m_x [N], m_y [N], m_w [N];
   logic [5:0]  m_c [N];
   logic [N-1:0] m_ist, m_ien, e_start, e_stop;
   logic [31:0] m_loop;

   task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [8:0] a);
      int c;
      if (a[1:0] != 2'b00) return '0;
      if (a < 9'h100) begin
         c = int'(a[7:4]);
         case (a[3:2])
            2'd0: return ch_cur_addr[c*32 +: 32];
            2'd1: return {16'h0, m_x[c]};
            2'd2: return {16'h0, m_y[c]};
            default: return {26'h0, m_c[c]};
         endcase
      end
      if (a < 9'h140) return {16'h0, m_w[int'(a[5:2])]};
      if (a == 9'h144) return {16'h0, m_ist};
      if (a == 9'h148) return {16'h0, m_ien};
      if (a == 9'h150) return m_loop;
      return '0;
   endfunction

   function automatic logic [N-1:0] exp_loop();
      return m_loop[N-1:0] & m_loop[31:16];
   endfunction

   task automatic model(input bit wr, input logic [8:0] a, input logic [31:0] d, input logic [N-1:0] ev);
      int c;
      e_start = '0;
      e_stop  = '0;
      if (wr) begin
         if (a[1:0] == 2'b00 && a < 9'h100) begin
            c = int'(a[7:4]);
            case (a[3:2])
               2'd0: begin m_base[c] = d; e_start[c] = 1'b1; end
               2'd1: m_x[c] = d[15:0];
               2'd2: m_y[c] = d[15:0];
               default: m_c[c] = d[5:0];
            endcase
         end else if (a[1:0] == 2'b00 && a < 9'h140 && a >= 9'h100) begin
            m_w[int'(a[5:2])] = d[15:0];
         end
         if (a == 9'h140) e_stop = d[N-1:0];
         if (a == 9'h144) m_ist = m_ist & ~d[N-1:0];
         if (a == 9'h148) m_ien = d[N-1:0];
         if (a == 9'h14C) m_ien = m_ien & ~d[N-1:0];
         if (a == 9'h150) m_loop = d;
         if (a == 9'h15C) m_loop = m_loop & ~d;
      end
      m_ist = m_ist | ev;
   endtask

   task automatic check_cfg();
      logic [N*32-1:0] eb;
      logic [N*16-1:0] ex, ey, ew;
      logic [N*4-1:0]  et;
      logic [N-1:0]    em, ed;
      for (int c = 0; c < N; c++) begin
         eb[c*32 +: 32] = m_base[c];
         ex[c*16 +: 16] = m_x[c];
         ey[c*16 +: 16] = m_y[c];
         ew[c*16 +: 16] = m_w[c];
         et[c*4 +: 4]   = m_c[c][3:0];
         em[c]          = m_c[c][4];
         ed[c]          = m_c[c][5];
      end
      chk(ch_base_addr == eb, "R3 base", ch_base_addr, eb);
      chk(ch_xlen == ex && ch_ylen == ey, "R2 xlen/ylen", {ch_xlen, ch_ylen}, {ex, ey});
      chk(ch_stride == ew, "R4 stride", ch_stride, ew);
      chk(ch_tag == et && ch_mode == em && ch_dir == ed, "R11 ctrl fields",
          {ch_tag, ch_mode, ch_dir}, {et, em, ed});
   endtask

   task automatic step(input bit wr, input logic [8:0] a, input logic [31:0] d, input logic [N-1:0] ev);
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = d; ch_event = ev;
      @(posedge clk);
      model(wr, a, d, ev);
      #2;
      reg_wr = 1'b0; ch_event = '0;
      chk(ch_start == e_start, "R3 start strobe", ch_start, e_start);
      chk(ch_stop == e_stop, "R9 stop strobe", ch_stop, e_stop);
      chk(irq == |(m_ist & m_ien), "R7 irq", irq, |(m_ist & m_ien));
      chk(ch_loop == exp_loop(), "R8 loop run", ch_loop, exp_loop());
   endtask

   task automatic rd(input logic [8:0] a, input string req);
      logic [31:0] e;
      reg_addr = a;
      #1;
      e = exp_read(a);
      chk(reg_rdata == e, req, reg_rdata, e);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [8:0] a;
      logic [31:0] d;
      logic [N-1:0] ev;
      int r;
      void'($urandom(32'd20240611));
      for (int c = 0; c < N; c++) begin
         ch_cur_addr[c*32 +: 32] = $urandom;
         m_base[c] = '0; m_x[c] = '0; m_y[c] = '0; m_w[c] = '0; m_c[c] = '0;
      end
      m_ist = '0; m_ien = '0; m_loop = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk(irq == 1'b0 && ch_start == '0 && ch_stop == '0 && ch_loop == '0, "R1 outputs",
          {irq, ch_start, ch_stop, ch_loop}, '0);
      check_cfg();
      for (int i = 0; i < 9'h160; i += 4) rd(9'(i), "R1 reset read");

      // R3: start strobe on one channel, then quiet
      step(1, 9'h050, 32'hDEAD_BEEF, '0);
      step(0, 9'h000, 32'h0, '0);
      rd(9'h050, "R3 live address read");
      // R2, R11, R4
      step(1, 9'h074, 32'hFFFF_1234, '0);
      step(1, 9'h078, 32'h0001_00AB, '0);
      step(1, 9'h07C, 32'hFFFF_FFEA, '0);
      step(1, 9'h11C, 32'h5555_0042, '0);
      check_cfg();
      rd(9'h07C, "R11 ctrl read");
      rd(9'h11C, "R4 stride read");
      // R5, R7: event sets, enable gates irq
      step(0, 9'h000, 0, 16'h0008);
      chk(irq == 1'b0, "R7 masked irq", irq, 0);
      step(1, 9'h148, 32'h0000_0008, '0);
      chk(irq == 1'b1, "R7 irq on", irq, 1);
      // R5: set and clear in the same cycle, set wins
      step(1, 9'h144, 32'h0000_0008, 16'h0008);
      rd(9'h144, "R5 set beats clear");
      step(1, 9'h144, 32'h0000_0008, '0);
      rd(9'h144, "R5 w1c");
      // R6: clear alias
      step(1, 9'h148, 32'h0000_F00F, '0);
      step(1, 9'h14C, 32'h0000_000F, '0);
      rd(9'h148, "R6 enable after clear alias");
      rd(9'h14C, "R6 alias reads zero");
      // R8: loop pairs
      step(1, 9'h150, 32'h0001_0001, '0);
      chk(ch_loop == 16'h0001, "R8 pair set", ch_loop, 16'h0001);
      step(1, 9'h150, 32'h0002_0001, '0);
      chk(ch_loop == 16'h0000, "R8 half pair", ch_loop, 16'h0000);
      step(1, 9'h150, 32'hFFFF_FFFF, '0);
      step(1, 9'h15C, 32'h0004_0000, '0);
      rd(9'h150, "R8 loop clear alias");
      rd(9'h15C, "R8 alias reads zero");
      // R9
      step(1, 9'h140, 32'h0000_8001, '0);
      step(0, 9'h000, 0, '0);
      rd(9'h140, "R9 stop reads zero");
      // R10: holes and misaligned writes
      step(1, 9'h1A0, 32'hFFFF_FFFF, '0);
      step(1, 9'h075, 32'hFFFF_FFFF, '0);
      step(1, 9'h146, 32'hFFFF_FFFF, '0);
      check_cfg();
      rd(9'h1A0, "R10 hole read");
      rd(9'h075, "R10 misaligned read");
      rd(9'h148, "R10 enable untouched");

      // random phase
      for (int i = 0; i < 3000; i++) begin
         r = $urandom % 8;
         d = $urandom;
         case (r)
            0, 1, 2: a = {1'b0, 4'($urandom), 2'($urandom), 2'b00};
            3:       a = 9'h100 + 9'({4'($urandom), 2'b00});
            4: begin
               case ($urandom % 6)
                  0: a = 9'h140; 1: a = 9'h144; 2: a = 9'h148;
                  3: a = 9'h14C; 4: a = 9'h150; default: a = 9'h15C;
               endcase
            end
            default: a = 9'($urandom);
         endcase
         ev = ($urandom % 4 == 0) ? N'($urandom & $urandom) : '0;
         step(r < 7, a, d, ev);
         rd(9'($urandom), "R10 random read");
         rd(a, "R2 random readback");
         if (i % 100 == 0) check_cfg();
      end
      check_cfg();

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule